// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Buffer

This block is the receive side of one isochronous OUT endpoint in a USB device controller. A packet-side interface marks the start of a packet, delivers its bytes one per valid cycle, and marks the end. The block stores the bytes in a 256-byte FIFO. Software sees a small register interface made of a control/status register, a data port that pops one byte per read, and a byte-count register.

Software picks one of two ways to service the endpoint. With DMA off, every packet that completes sets the packet-complete flag and the endpoint interrupt status. Software then reads the bytes through the data port and acknowledges the packet. With DMA on, a DMA request drains the FIFO in fixed 32-byte bursts. Software is only called in when a tail of fewer than 32 bytes remains, or when the packet had no data at all. A start-of-frame interrupt lets software service the endpoint once per frame count instead of once per packet. Isochronous traffic is never retried, so a packet that arrives before the previous one is acknowledged is dropped, and a sticky overrun flag is set.

The packet receiver is a state machine with four states:
- `P_IDLE` waits for a start strobe. It goes to `P_RECV` when the endpoint is free, and to `P_DROP` when it is busy (overrun).
- `P_RECV` stores bytes. On the end strobe it goes back to `P_IDLE` with the packet complete when DMA is off, and to `P_DRAIN` when DMA is on.
- `P_DRAIN` waits until fewer than 32 bytes remain and no burst is running, then returns to `P_IDLE`.
- `P_DROP` discards bytes until the end strobe and then returns to `P_IDLE`.

The DMA sequencer has two states:
- `D_IDLE` goes to `D_BURST` when DMA is enabled and at least 32 bytes are held.
- `D_BURST` asserts the request and returns to `D_IDLE` after 32 acknowledged beats.

Top module: `iso_out_rx`

## Requirements
- R1: After reset the control/status register reads 0, the count reads 0, and `ep_irq`, `sof_irq` and `dma_req` are low. That is, the FIFO is empty, all flags are clear, both interrupt enables are off and DMA is disabled.
- R2: With DMA off, each packet's end strobe sets the packet-complete flag and the endpoint interrupt status. Both are visible by the second falling clock edge after the end strobe. `ep_irq` equals the endpoint status ANDed with the endpoint interrupt enable.
- R3: A zero-length packet (start strobe followed by end strobe) completes with packet-complete set, short set, not-empty clear and a count of 0.
- R4: The count register (address 2) always equals the number of unread bytes, from 0 to 256. Not-empty is set exactly when the count is non-zero. Each `reg_rd` at the data port (address 1) pops one byte in arrival order, and `reg_rdata[7:0]` shows the head byte.
- R5: When a packet completes, the short flag is loaded with 1 if the packet length is zero or not a multiple of 32, and with 0 otherwise. A 256-byte packet therefore completes with short clear.
- R6: Packet-complete, short, endpoint status, SOF status and overrun are cleared by writing 1 to their bit. Writing 0 leaves them unchanged. After packet-complete is cleared, the next packet is accepted.
- R7: A packet whose start strobe arrives while packet-complete is set, or while a DMA-mode packet is still draining, is dropped. The count stays unchanged and the overrun flag is set. Overrun stays set until it is cleared by writing 1.
- R8: With DMA on, `dma_req` rises only when at least 32 unread bytes are held. Each burst consists of exactly 32 cycles with `dma_ack` high, and each of those cycles pops one byte, shown on `dma_data`. After the burst, `dma_req` is low whenever fewer than 32 bytes remain.
- R9: With DMA on, a packet whose length is not a multiple of 32 ends with packet-complete, short and endpoint status set once the bursts have left its tail of under 32 bytes. A packet whose length is a non-zero multiple of 32 is fully drained by DMA and leaves packet-complete clear.
- R10: Packets shorter than 32 bytes never raise `dma_req`. They complete with all their bytes left for the data port.
- R11: A `sof_pulse` sets the SOF status. `sof_irq` equals the SOF status ANDed with the SOF interrupt enable.
- R12: The control/status register is at address 0. Its bits are:
  - bit 0: DMA enable (read/write)
  - bit 1: endpoint interrupt enable (read/write)
  - bit 2: SOF interrupt enable (read/write)
  - bit 3: packet-complete (write 1 to clear)
  - bit 4: short (write 1 to clear)
  - bit 5: endpoint status (write 1 to clear)
  - bit 6: SOF status (write 1 to clear)
  - bit 7: overrun (write 1 to clear)
  - bit 8: not-empty (read-only)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_sop | input | 1 | Packet start strobe, one cycle, no data |
| pkt_valid | input | 1 | Data byte valid |
| pkt_data | input | 8 | Received data byte |
| pkt_eop | input | 1 | Packet end strobe, one cycle, no data |
| sof_pulse | input | 1 | Start-of-frame pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at the data port) |
| reg_addr | input | 2 | Register address: 0 control/status, 1 data, 2 count |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| dma_req | output | 1 | DMA burst request |
| dma_ack | input | 1 | DMA beat acknowledge, pops one byte |
| dma_data | output | 8 | FIFO head byte for DMA |
| ep_irq | output | 1 | Endpoint interrupt |
| sof_irq | output | 1 | Start-of-frame interrupt |

## Verification
The bench goes after the two kinds of packet that look alike: a zero-length packet and a short packet. A design that mixes them up would report a non-zero count or a clear short flag after an empty packet. In DMA mode it sends lengths of 70, 64 and 20 bytes. A wrong burst rule would show up as a request for the 20-byte packet, a stray packet-complete after the exact 64-byte packet, or a tail count other than 6. It also sends a second packet before acknowledging the first. A design that accepts it would show a count above 10 or a clear overrun flag. It writes zeros to the write-one-to-clear bits to catch clear logic that is level-based, and sends a full 256-byte packet to catch an off-by-one in the count.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
    localparam logic [1:0] ADDR_CSR  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    localparam int B_DMAEN = 0;
    localparam int B_EPIE  = 1;
    localparam int B_SOFIE = 2;
    localparam int B_RPC   = 3;
    localparam int B_SHORT = 4;
    localparam int B_EPIS  = 5;
    localparam int B_SOFIS = 6;
    localparam int B_OVR   = 7;
    localparam int B_RNE   = 8;

    typedef enum logic [1:0] {P_IDLE, P_RECV, P_DRAIN, P_DROP} pkt_state_e;
    typedef enum logic       {D_IDLE, D_BURST} dma_state_e;
endpackage

// File: rtl/iso_rx_fifo.sv
module iso_rx_fifo #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/iso_rx_pkt_fsm.sv
module iso_rx_pkt_fsm
    import iso_rx_pkg::*;
#(
    parameter int BURST = 32,
    parameter int LVL_W = 9,
    localparam int BAW  = $clog2(BURST)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sop,
    input  logic             valid,
    input  logic             eop,
    input  logic             dma_en,
    input  logic             ep_busy,
    input  logic             fifo_full,
    input  logic [LVL_W-1:0] level,
    input  logic             dma_idle,
    output logic             push,
    output logic             done,
    output logic             done_short,
    output logic             ovr_set
);
    localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST);

    pkt_state_e       state, nxt;
    logic [LVL_W-1:0] len;
    logic             len_short;

    assign len_short = (len[BAW-1:0] != '0) || (len == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= P_IDLE;
            len   <= '0;
        end else begin
            state <= nxt;
            if (state == P_IDLE && sop)  len <= '0;
            else if (push)               len <= len + LVL_W'(1);
        end
    end

    always_comb begin
        nxt        = state;
        push       = 1'b0;
        done       = 1'b0;
        done_short = len_short;
        ovr_set    = 1'b0;
        unique case (state)
            P_IDLE: begin
                if (sop) begin
                    if (ep_busy) begin
                        nxt     = P_DROP;
                        ovr_set = 1'b1;
                    end else begin
                        nxt = P_RECV;
                    end
                end
            end
            P_RECV: begin
                if (valid) begin
                    push    = !fifo_full;
                    ovr_set = fifo_full;
                end
                if (eop) begin
                    if (dma_en) begin
                        nxt = P_DRAIN;
                    end else begin
                        nxt  = P_IDLE;
                        done = 1'b1;
                    end
                end
            end
            P_DRAIN: begin
                if (sop) ovr_set = 1'b1;
                if (level < BURST_L && dma_idle) begin
                    nxt  = P_IDLE;
                    done = len_short;
                end
            end
            P_DROP: begin
                if (eop) nxt = P_IDLE;
            end
            default: nxt = P_IDLE;
        endcase
    end
endmodule

// File: rtl/iso_rx_dma_fsm.sv
module iso_rx_dma_fsm
    import iso_rx_pkg::*;
#(
    parameter int BURST = 32,
    parameter int LVL_W = 9,
    localparam int BAW  = $clog2(BURST)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic [LVL_W-1:0] level,
    input  logic             dma_ack,
    output logic             dma_req,
    output logic             dma_pop,
    output logic             idle
);
    localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST);
    localparam logic [BAW-1:0]   LAST    = BAW'(BURST - 1);

    dma_state_e     state, nxt;
    logic [BAW-1:0] beat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= D_IDLE;
            beat  <= '0;
        end else begin
            state <= nxt;
            if (state == D_IDLE) beat <= '0;
            else if (dma_pop)    beat <= beat + BAW'(1);
        end
    end

    always_comb begin
        nxt     = state;
        dma_req = 1'b0;
        dma_pop = 1'b0;
        idle    = 1'b0;
        unique case (state)
            D_IDLE: begin
                idle = 1'b1;
                if (dma_en && level >= BURST_L) nxt = D_BURST;
            end
            D_BURST: begin
                dma_req = 1'b1;
                dma_pop = dma_ack;
                if (dma_ack && beat == LAST) nxt = D_IDLE;
            end
            default: nxt = D_IDLE;
        endcase
    end
endmodule

// File: rtl/iso_out_rx.sv
module iso_out_rx
    import iso_rx_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int BURST  = 32,
    parameter int REG_W  = 16,
    localparam int DATA_W = 8,
    localparam int LVL_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_sop,
    input  logic              pkt_valid,
    input  logic [DATA_W-1:0] pkt_data,
    input  logic              pkt_eop,
    input  logic              sof_pulse,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic [DATA_W-1:0] dma_data,
    output logic              ep_irq,
    output logic              sof_irq
);
    logic dma_en_q, ep_ie_q, sof_ie_q;
    logic rpc_q, short_q, ep_is_q, sof_is_q, ovr_q;

    logic [LVL_W-1:0]  level;
    logic [DATA_W-1:0] head;
    logic              full, empty, push, sw_pop, dma_pop, dma_idle;
    logic              done, done_short, ovr_set;
    logic              csr_wr;
    logic [8:0]        csr_view;

    assign csr_wr = reg_wr && (reg_addr == ADDR_CSR);
    assign sw_pop = reg_rd && (reg_addr == ADDR_DATA) && !empty && !dma_pop;

    iso_rx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (pkt_data),
        .pop   (sw_pop || dma_pop),
        .dout  (head),
        .level (level),
        .full  (full),
        .empty (empty)
    );

    iso_rx_pkt_fsm #(.BURST(BURST), .LVL_W(LVL_W)) i_pkt (
        .clk        (clk),
        .rst_n      (rst_n),
        .sop        (pkt_sop),
        .valid      (pkt_valid),
        .eop        (pkt_eop),
        .dma_en     (dma_en_q),
        .ep_busy    (rpc_q),
        .fifo_full  (full),
        .level      (level),
        .dma_idle   (dma_idle),
        .push       (push),
        .done       (done),
        .done_short (done_short),
        .ovr_set    (ovr_set)
    );

    iso_rx_dma_fsm #(.BURST(BURST), .LVL_W(LVL_W)) i_dma (
        .clk     (clk),
        .rst_n   (rst_n),
        .dma_en  (dma_en_q),
        .level   (level),
        .dma_ack (dma_ack),
        .dma_req (dma_req),
        .dma_pop (dma_pop),
        .idle    (dma_idle)
    );

    // Control and status: set events take priority over write-one-to-clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_en_q <= 1'b0;
            ep_ie_q  <= 1'b0;
            sof_ie_q <= 1'b0;
            rpc_q    <= 1'b0;
            short_q  <= 1'b0;
            ep_is_q  <= 1'b0;
            sof_is_q <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            if (csr_wr) begin
                dma_en_q <= reg_wdata[B_DMAEN];
                ep_ie_q  <= reg_wdata[B_EPIE];
                sof_ie_q <= reg_wdata[B_SOFIE];
            end
            if (done)                             rpc_q <= 1'b1;
            else if (csr_wr && reg_wdata[B_RPC])  rpc_q <= 1'b0;
            if (done)                             short_q <= done_short;
            else if (csr_wr && reg_wdata[B_SHORT]) short_q <= 1'b0;
            if (done)                             ep_is_q <= 1'b1;
            else if (csr_wr && reg_wdata[B_EPIS]) ep_is_q <= 1'b0;
            if (sof_pulse)                         sof_is_q <= 1'b1;
            else if (csr_wr && reg_wdata[B_SOFIS]) sof_is_q <= 1'b0;
            if (ovr_set)                          ovr_q <= 1'b1;
            else if (csr_wr && reg_wdata[B_OVR])  ovr_q <= 1'b0;
        end
    end

    assign csr_view = {!empty, ovr_q, sof_is_q, ep_is_q, short_q, rpc_q,
                       sof_ie_q, ep_ie_q, dma_en_q};

    always_comb begin
        unique case (reg_addr)
            ADDR_CSR:  reg_rdata = REG_W'(csr_view);
            ADDR_DATA: reg_rdata = REG_W'(head);
            ADDR_CNT:  reg_rdata = REG_W'(level);
            default:   reg_rdata = '0;
        endcase
    end

    assign dma_data = head;
    assign ep_irq   = ep_is_q && ep_ie_q;
    assign sof_irq  = sof_is_q && sof_ie_q;
endmodule

// File: rtl/iso_out_rx_chk.sv
module iso_out_rx_chk #(
    parameter int DEPTH = 256,
    parameter int BURST = 32,
    parameter int LVL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_req,
    input logic             dma_en,
    input logic [LVL_W-1:0] level,
    input logic             rpc,
    input logic             short_f,
    input logic             ep_is,
    input logic             sof_pulse,
    input logic             sof_is,
    input logic             ovr,
    input logic             ovr_clr
);
    AST_REQ_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> (dma_en && level >= LVL_W'(BURST))); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R4
    AST_EMPTY_PKT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rpc) && level == '0) |-> short_f); // R3
    AST_COMPLETE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rpc) |-> ep_is); // R2
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovr) && !$past(ovr_clr)) |-> ovr); // R7
    AST_SOF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sof_pulse) |-> sof_is); // R11
endmodule

bind iso_out_rx iso_out_rx_chk #(.DEPTH(DEPTH), .BURST(BURST), .LVL_W(LVL_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_req   (dma_req),
    .dma_en    (dma_en_q),
    .level     (level),
    .rpc       (rpc_q),
    .short_f   (short_q),
    .ep_is     (ep_is_q),
    .sof_pulse (sof_pulse),
    .sof_is    (sof_is_q),
    .ovr       (ovr_q),
    .ovr_clr   (csr_wr && reg_wdata[7])
);

// File: tb/test_iso_out_rx.sv
module test_iso_out_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_sop = 0, pkt_valid = 0, pkt_eop = 0, sof_pulse = 0;
    logic [7:0]  pkt_data = 0;
    logic        reg_wr = 0, reg_rd = 0, dma_ack = 0;
    logic [1:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        dma_req, ep_irq, sof_irq;
    logic [7:0]  dma_data;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    iso_out_rx i_iso_out_rx (
        .clk(clk), .rst_n(rst_n), .pkt_sop(pkt_sop), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_eop(pkt_eop), .sof_pulse(sof_pulse),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_data(dma_data), .ep_irq(ep_irq), .sof_irq(sof_irq)
    );

    // CSR bits: 0 dma_en 1 ep_ie 2 sof_ie 3 rpc 4 short 5 ep_is 6 sof_is 7 ovr 8 rne
    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr_csr(input logic [7:0] d);
        reg_addr = 2'd0; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic send_pkt(input int len, input logic [7:0] base);
        pkt_sop = 1'b1;
        @(negedge clk);
        pkt_sop = 1'b0;
        for (int i = 0; i < len; i++) begin
            pkt_valid = 1'b1; pkt_data = base + 8'(i);
            @(negedge clk);
        end
        pkt_valid = 1'b0;
        pkt_eop = 1'b1;
        @(negedge clk);
        pkt_eop = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic sw_read(input string req, input int n, input logic [7:0] base);
        int bad = 0;
        int first_got = 0, first_exp = 0;
        reg_addr = 2'd1; reg_rd = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            if (reg_rdata[7:0] != base + 8'(i) && bad == 0) begin
                bad = 1; first_got = int'(reg_rdata[7:0]); first_exp = int'(base + 8'(i));
            end
            @(negedge clk);
        end
        reg_rd = 1'b0;
        chk(req, bad ? first_got : first_exp, first_exp);
    endtask

    task automatic dma_burst(input string req, input logic [7:0] base);
        int bad = 0;
        int waits = 0;
        while (!dma_req && waits < 100) begin
            @(negedge clk); waits++;
        end
        chk({req, " request"}, int'(dma_req), 1);
        dma_ack = 1'b1;
        for (int i = 0; i < 32; i++) begin
            #1;
            if (dma_data != base + 8'(i)) bad++;
            @(negedge clk);
        end
        dma_ack = 1'b0;
        chk({req, " burst data errors"}, bad, 0);
    endtask

    task automatic t_reset;
        int v;
        rd_reg(2'd0, v); chk("R1 csr", v, 0);
        rd_reg(2'd2, v); chk("R1 count", v, 0);
        chk("R1 irq/req", int'({ep_irq, sof_irq, dma_req}), 0);
    endtask

    task automatic t_sw_packet;
        int v;
        wr_csr(8'h02);
        send_pkt(10, 8'h40);
        rd_reg(2'd0, v); chk("R2 rpc+epis", (v >> 3) & 5, 5);
        chk("R2 ep_irq", int'(ep_irq), 1);
        chk("R5 short on 10", (v >> 4) & 1, 1);
        chk("R12 rne", (v >> 8) & 1, 1);
        rd_reg(2'd2, v); chk("R4 count 10", v, 10);
        // R7: second packet while rpc set is dropped
        send_pkt(5, 8'h90);
        rd_reg(2'd2, v); chk("R7 count kept", v, 10);
        rd_reg(2'd0, v); chk("R7 ovr set", (v >> 7) & 1, 1);
        sw_read("R4 data order", 10, 8'h40);
        rd_reg(2'd2, v); chk("R4 count drained", v, 0);
        rd_reg(2'd0, v); chk("R4 rne clear", (v >> 8) & 1, 0);
        wr_csr(8'h02);
        rd_reg(2'd0, v); chk("R6 write0 keeps", (v >> 3) & 8'h1F, 8'h17);
        wr_csr(8'h02 | 8'h38);
        rd_reg(2'd0, v); chk("R7 ovr sticky", (v >> 7) & 1, 1);
        chk("R6 w1c cleared", (v >> 3) & 7, 0);
        chk("R2 ep_irq low", int'(ep_irq), 0);
        wr_csr(8'h82);
        rd_reg(2'd0, v); chk("R6 ovr cleared", v, 2);
    endtask

    task automatic t_zlp;
        int v;
        send_pkt(0, 8'h00);
        rd_reg(2'd0, v);
        chk("R3 rpc/short/rne", ((v >> 3) & 3) | ((v >> 6) & 4), 3);
        rd_reg(2'd2, v); chk("R3 count", v, 0);
        wr_csr(8'h3A);
    endtask

    task automatic t_full;
        int v;
        int req_seen = 0;
        fork
            send_pkt(256, 8'h00);
            repeat (262) begin @(negedge clk); #2; if (dma_req) req_seen = 1; end
        join
        rd_reg(2'd2, v); chk("R4 count 256", v, 256);
        rd_reg(2'd0, v); chk("R5 short clear on 256", (v >> 3) & 3, 1);
        chk("R8 no req with dma off", req_seen, 0);
        sw_read("R4 full data", 256, 8'h00);
        wr_csr(8'h3A);
    endtask

    task automatic t_dma_tail;
        int v;
        wr_csr(8'h03);
        send_pkt(70, 8'h10);
        dma_burst("R8 first", 8'h10);
        dma_burst("R8 second", 8'h30);
        repeat (4) @(negedge clk);
        chk("R8 req low under 32", int'(dma_req), 0);
        rd_reg(2'd2, v); chk("R9 tail count", v, 6);
        rd_reg(2'd0, v); chk("R9 rpc/short/epis", (v >> 3) & 7, 7);
        sw_read("R9 tail data", 6, 8'h50);
        wr_csr(8'h3B);
    endtask

    task automatic t_dma_exact;
        int v;
        send_pkt(64, 8'hA0);
        dma_burst("R8 exact first", 8'hA0);
        dma_burst("R8 exact second", 8'hC0);
        repeat (4) @(negedge clk);
        rd_reg(2'd0, v); chk("R9 exact no rpc", (v >> 3) & 1, 0);
        rd_reg(2'd2, v); chk("R9 exact count", v, 0);
    endtask

    task automatic t_dma_small;
        int v;
        int req_seen = 0;
        fork
            send_pkt(20, 8'h70);
            repeat (26) begin @(negedge clk); #2; if (dma_req) req_seen = 1; end
        join
        chk("R10 no request", req_seen, 0);
        rd_reg(2'd0, v); chk("R10 rpc", (v >> 3) & 1, 1);
        rd_reg(2'd2, v); chk("R10 count", v, 20);
        sw_read("R10 data", 20, 8'h70);
        wr_csr(8'h3A);
    endtask

    task automatic t_sof;
        int v;
        sof_pulse = 1'b1; @(negedge clk); sof_pulse = 1'b0; @(negedge clk);
        rd_reg(2'd0, v); chk("R11 sof status", (v >> 6) & 1, 1);
        chk("R11 irq masked", int'(sof_irq), 0);
        wr_csr(8'h04);
        chk("R11 irq enabled", int'(sof_irq), 1);
        wr_csr(8'h44);
        chk("R11 cleared", int'(sof_irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_packet();
        t_zlp();
        t_full();
        t_dma_tail();
        t_dma_exact();
        t_dma_small();
        t_sof();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule